// File: doc/BRIEF.md
# Disk Sector ID Search Unit

This unit searches a spinning track for the address field of one requested sector. A start strobe loads four target values: cylinder, side, sector number and size code. From then on the unit accepts decoded ID records from an upstream separator model. Each record carries those four fields, an address-mark-seen flag and a CRC-good flag.

Records that carry an address mark and a good CRC are compared field by field against the targets. A full match ends the search at once with a one-cycle `found` pulse and clean status. A record that does not match is noted and skipped, and the search carries on. A record with a bad CRC ends the search at once with an error. If the track passes the index mark twice before any match, the search gives up. The error status then says why: no address mark at all, the wrong or a bad cylinder, or another field that differed.

The ID record input is a valid/ready stream. `id_ready` is high exactly while a search is in progress. A record is taken on a clock edge where `id_valid` and `id_ready` are both high. Upstream may hold a record while `id_ready` is low, and nothing is lost. Records offered while idle are never consumed.

Top module: `sector_id_search`

## Requirements
- R1: A `start` pulse loads the four targets, clears st0/st1/st2 and the index count, and raises `busy` from the next cycle. A `start` during a search restarts it. An index pulse in the same cycle as `start` is not counted.
- R2: `id_ready` equals `busy`. A record is consumed only when `id_valid` and `id_ready` are both high. Records offered while idle change no output.
- R3: A consumed record with `id_am`=1, `id_crc_ok`=1 and all four fields equal to the targets gives `found`=1 for exactly one cycle, in the cycle after the accepting edge. At that point st0, st1 and st2 are all 00h and `busy` is 0.
- R4: A consumed record with a good CRC and at least one differing field does not end the search. `busy` stays 1 and later records are still compared.
- R5: A consumed record with `id_am`=0 is skipped: it is neither compared nor counted as an address mark.
- R6: The second index pulse counted during a search ends it unless a hit or CRC error ends it in the same cycle. `fail` is then 1 for one cycle and st0 = 40h (bits 7:6 = 01). The first index pulse does not end the search.
- R7: At an index termination, if the last compared record had a different cylinder, st2 bit 4 is set. If that cylinder value was FFh, st2 bit 1 is set instead. Otherwise st2 = 00h.
- R8: At an index termination, st1 bit 2 is set when the last compared record differed in side, sector or size code.
- R9: At an index termination, st1 bit 0 is set when no record with `id_am`=1 was consumed during the search.
- R10: A consumed record with `id_am`=1 and `id_crc_ok`=0 ends the search at once with `fail`, st0 = 40h, st1 = 20h (bit 5) and st2 = 00h.
- R11: When a record is consumed in the same cycle as the terminating index pulse, the record is evaluated first. A hit or CRC error decides the outcome. A mismatch becomes the last record used for R7/R8.
- R12: st0, st1 and st2 hold their values from the end of a search until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin or restart a search |
| tgt_track | input | 8 | Target cylinder, loaded on start |
| tgt_head | input | 8 | Target side, loaded on start |
| tgt_sector | input | 8 | Target sector number, loaded on start |
| tgt_size | input | 8 | Target size code, loaded on start |
| id_valid | input | 1 | ID record valid |
| id_ready | output | 1 | ID record accepted (high while searching) |
| id_track | input | 8 | Record cylinder |
| id_head | input | 8 | Record side |
| id_sector | input | 8 | Record sector number |
| id_size | input | 8 | Record size code |
| id_am | input | 1 | Address mark seen for this record |
| id_crc_ok | input | 1 | Record CRC good |
| index_pulse | input | 1 | One-cycle index mark |
| busy | output | 1 | Search in progress |
| found | output | 1 | One-cycle hit pulse |
| fail | output | 1 | One-cycle error termination pulse |
| st0 | output | 8 | Status 0 (interrupt code in bits 7:6) |
| st1 | output | 8 | Status 1 (bits 5, 2, 0) |
| st2 | output | 8 | Status 2 (bits 4, 1) |

## Verification
The hardest case to reach is a consumed record landing in the same cycle as the second index pulse. There the record's verdict and the index give-up compete, and the status must reflect the record that arrived in that very cycle. The stimulus lines up a record beat with the second index pulse three times: once with a hit, once with a CRC error and once with a new mismatch. It also places an index pulse on the start cycle, to check that it is not counted.

// File: rtl/sis_pkg.sv
package sis_pkg;
  // Per-record mismatch classification
  typedef struct packed {
    logic trk;  // cylinder differs
    logic bad;  // cylinder read as all ones
    logic oth;  // side, sector or size differs
  } miss_t;

  localparam logic [7:0] IC_ABNORMAL = 8'h40;
endpackage

// File: rtl/sis_compare.sv
module sis_compare
  import sis_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] tgt_track,
  input  logic [W-1:0] tgt_head,
  input  logic [W-1:0] tgt_sector,
  input  logic [W-1:0] tgt_size,
  input  logic [W-1:0] id_track,
  input  logic [W-1:0] id_head,
  input  logic [W-1:0] id_sector,
  input  logic [W-1:0] id_size,
  output logic         all_eq,
  output miss_t        miss
);
  localparam int NF = 4;
  logic [NF-1:0][W-1:0] tv, iv;
  logic [NF-1:0]        eq;

  // Field order: cylinder, side, sector, size
  assign tv = {tgt_size, tgt_sector, tgt_head, tgt_track};
  assign iv = {id_size, id_sector, id_head, id_track};

  for (genvar g = 0; g < NF; g++) begin : g_cmp
    assign eq[g] = (tv[g] == iv[g]);
  end

  assign all_eq   = &eq;
  assign miss.trk = ~eq[0];
  assign miss.bad = &id_track;
  assign miss.oth = ~&eq[NF-1:1];
endmodule

// File: rtl/sis_index_cnt.sv
module sis_index_cnt #(
  parameter int LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic pulse,
  output logic reached
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  logic [CW-1:0] cnt_q;

  assign reached = en && pulse && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (clr)                   cnt_q <= '0;
    else if (en && pulse && !reached) cnt_q <= cnt_q + 1'b1;
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(LIMIT)); // R6
endmodule

// File: rtl/sis_status.sv
module sis_status
  import sis_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       rec_en,
  input  miss_t      rec_miss,
  input  logic       term_idx,
  input  logic       term_crc,
  output logic [7:0] st0,
  output logic [7:0] st1,
  output logic [7:0] st2
);
  logic  am_seen_q;
  miss_t miss_q;
  logic  am_eff;
  miss_t miss_eff;

  // Fold in the record arriving in the terminating cycle
  assign am_eff   = am_seen_q | rec_en;
  assign miss_eff = rec_en ? rec_miss : miss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      am_seen_q <= 1'b0;
      miss_q    <= '0;
      st0 <= '0; st1 <= '0; st2 <= '0;
    end else if (clr) begin
      am_seen_q <= 1'b0;
      miss_q    <= '0;
      st0 <= '0; st1 <= '0; st2 <= '0;
    end else begin
      if (rec_en) begin
        am_seen_q <= 1'b1;
        miss_q    <= rec_miss;
      end
      if (term_crc) begin
        st0 <= IC_ABNORMAL;
        st1 <= 8'h20;
        st2 <= 8'h00;
      end else if (term_idx) begin
        st0 <= IC_ABNORMAL;
        st1 <= {5'b0, miss_eff.oth, 1'b0, ~am_eff};
        st2 <= {3'b0, miss_eff.trk & ~miss_eff.bad, 2'b0, miss_eff.trk & miss_eff.bad, 1'b0};
      end
    end
  end

  AST_TRK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(st2[4] && st2[1])); // R7
  AST_AM_NO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    st1[0] |-> (st2 == 8'h00 && !st1[2])); // R9
endmodule

// File: rtl/sector_id_search.sv
module sector_id_search
  import sis_pkg::*;
#(
  parameter int W         = 8,
  parameter int IDX_LIMIT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] tgt_track,
  input  logic [W-1:0] tgt_head,
  input  logic [W-1:0] tgt_sector,
  input  logic [W-1:0] tgt_size,
  input  logic         id_valid,
  output logic         id_ready,
  input  logic [W-1:0] id_track,
  input  logic [W-1:0] id_head,
  input  logic [W-1:0] id_sector,
  input  logic [W-1:0] id_size,
  input  logic         id_am,
  input  logic         id_crc_ok,
  input  logic         index_pulse,
  output logic         busy,
  output logic         found,
  output logic         fail,
  output logic [7:0]   st0,
  output logic [7:0]   st1,
  output logic [7:0]   st2
);
  logic [W-1:0] t_trk_q, t_hd_q, t_sec_q, t_sz_q;
  logic busy_q, found_q, fail_q;
  logic acc, all_eq, hit, crc_bad, mism, idx_done, term_idx;
  miss_t miss;

  assign acc      = id_valid && busy_q;
  assign hit      = acc && id_am && id_crc_ok && all_eq;
  assign crc_bad  = acc && id_am && !id_crc_ok;
  assign mism     = acc && id_am && id_crc_ok && !all_eq;
  assign term_idx = idx_done && !hit && !crc_bad;

  sis_compare #(.W(W)) u_cmp (
    .tgt_track(t_trk_q), .tgt_head(t_hd_q), .tgt_sector(t_sec_q), .tgt_size(t_sz_q),
    .id_track(id_track), .id_head(id_head), .id_sector(id_sector), .id_size(id_size),
    .all_eq(all_eq), .miss(miss)
  );

  sis_index_cnt #(.LIMIT(IDX_LIMIT)) u_idx (
    .clk(clk), .rst_n(rst_n), .clr(start), .en(busy_q && !start),
    .pulse(index_pulse), .reached(idx_done)
  );

  sis_status u_st (
    .clk(clk), .rst_n(rst_n), .clr(start),
    .rec_en(mism), .rec_miss(miss),
    .term_idx(term_idx), .term_crc(crc_bad),
    .st0(st0), .st1(st1), .st2(st2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      found_q <= 1'b0;
      fail_q  <= 1'b0;
      t_trk_q <= '0; t_hd_q <= '0; t_sec_q <= '0; t_sz_q <= '0;
    end else begin
      found_q <= hit && !start;
      fail_q  <= (crc_bad || term_idx) && !start;
      if (start) begin
        busy_q  <= 1'b1;
        t_trk_q <= tgt_track; t_hd_q <= tgt_head;
        t_sec_q <= tgt_sector; t_sz_q <= tgt_size;
      end else if (hit || crc_bad || term_idx) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign id_ready = busy_q;
  assign busy     = busy_q;
  assign found    = found_q;
  assign fail     = fail_q;

  AST_FOUND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> !found); // R3
  AST_FOUND_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (st0 == 8'h00 && st1 == 8'h00 && st2 == 8'h00 && !busy)); // R3
  AST_FAIL_IC: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (st0 == 8'h40 && !busy)); // R6
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(found && fail)); // R3
  AST_CRC_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && id_ready && id_am && !id_crc_ok && !start) |=> (fail && st1 == 8'h20)); // R10
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && st0 == 8'h00)); // R1
endmodule

// File: tb/sim_sector_id_search.sv
module sim_sector_id_search;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, id_valid = 0, id_am = 0, id_crc_ok = 0, index_pulse = 0;
  logic [7:0] tgt_track = 0, tgt_head = 0, tgt_sector = 0, tgt_size = 0;
  logic [7:0] id_track = 0, id_head = 0, id_sector = 0, id_size = 0;
  logic id_ready, busy, found, fail;
  logic [7:0] st0, st1, st2;

  always #10 clk = ~clk; // 50 MHz

  sector_id_search u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .tgt_track(tgt_track), .tgt_head(tgt_head), .tgt_sector(tgt_sector), .tgt_size(tgt_size),
    .id_valid(id_valid), .id_ready(id_ready),
    .id_track(id_track), .id_head(id_head), .id_sector(id_sector), .id_size(id_size),
    .id_am(id_am), .id_crc_ok(id_crc_ok), .index_pulse(index_pulse),
    .busy(busy), .found(found), .fail(fail), .st0(st0), .st1(st1), .st2(st2)
  );

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  // Behavioural reference state
  int m_busy = 0, m_found = 0, m_fail = 0, m_idx = 0, m_am = 0;
  int m_trk = 0, m_bad = 0, m_oth = 0;
  int m_st0 = 0, m_st1 = 0, m_st2 = 0;
  int t_trk = 0, t_hd = 0, t_sec = 0, t_sz = 0;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", cur_req, what, act, exp, cycles);
    end
  endtask

  task automatic model_edge();
    m_found = 0; m_fail = 0;
    if (start) begin
      m_busy = 1; m_idx = 0; m_am = 0; m_trk = 0; m_bad = 0; m_oth = 0;
      m_st0 = 0; m_st1 = 0; m_st2 = 0;
      t_trk = tgt_track; t_hd = tgt_head; t_sec = tgt_sector; t_sz = tgt_size;
    end else if (m_busy == 1) begin
      if (id_valid && id_am) begin
        if (!id_crc_ok) begin
          m_fail = 1; m_busy = 0; m_st0 = 'h40; m_st1 = 'h20; m_st2 = 0;
        end else if (id_track == t_trk && id_head == t_hd && id_sector == t_sec && id_size == t_sz) begin
          m_found = 1; m_busy = 0;
        end else begin
          m_am = 1;
          m_trk = (id_track != t_trk);
          m_bad = (id_track == 8'hFF);
          m_oth = (id_head != t_hd) || (id_sector != t_sec) || (id_size != t_sz);
        end
      end
      if (m_busy == 1 && index_pulse) begin
        m_idx++;
        if (m_idx == 2) begin
          m_fail = 1; m_busy = 0; m_st0 = 'h40;
          m_st1 = (m_oth ? 4 : 0) + (m_am ? 0 : 1);
          m_st2 = m_trk ? (m_bad ? 2 : 'h10) : 0;
        end
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #5;
    cycles++;
    chk("busy", busy, m_busy);
    chk("id_ready", id_ready, m_busy);
    chk("found", found, m_found);
    chk("fail", fail, m_fail);
    chk("st0", st0, m_st0);
    chk("st1", st1, m_st1);
    chk("st2", st2, m_st2);
    start = 0; id_valid = 0; index_pulse = 0;
  endtask

  task automatic go(input int tr, input int hd, input int sc, input int sz);
    tgt_track = 8'(tr); tgt_head = 8'(hd); tgt_sector = 8'(sc); tgt_size = 8'(sz);
    start = 1; step();
  endtask

  task automatic rec(input int tr, input int hd, input int sc, input int sz,
                     input logic am, input logic ok, input logic idx);
    id_valid = 1; id_track = 8'(tr); id_head = 8'(hd); id_sector = 8'(sc); id_size = 8'(sz);
    id_am = am; id_crc_ok = ok; index_pulse = idx;
    step();
  endtask

  task automatic idx();
    index_pulse = 1; step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // Watchdog
  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #35;
    cur_req = "R1";
    chk("reset busy", busy, 0); chk("reset st0", st0, 0);
    chk("reset st1", st1, 0); chk("reset st2", st2, 0);
    rst_n = 1;
    idle(2);

    // R2: records while idle are not consumed
    cur_req = "R2";
    rec(3, 0, 5, 2, 1, 0, 0);
    idle(1);

    // R3: immediate hit
    cur_req = "R3";
    go(3, 0, 5, 2);
    rec(3, 0, 5, 2, 1, 1, 0);
    idle(2);

    // R4: sector mismatch then hit, one index in between
    cur_req = "R4";
    go(10, 1, 7, 2);
    rec(10, 1, 6, 2, 1, 1, 0);
    idx();
    idle(2);
    rec(10, 1, 7, 2, 1, 1, 0);
    idle(1);

    // R7 wrong cylinder, R12 status holds afterwards
    cur_req = "R7";
    go(20, 0, 1, 2);
    rec(21, 0, 1, 2, 1, 1, 0);
    idx(); idle(1); idx();
    cur_req = "R12";
    idle(3);

    // R7 bad cylinder FFh
    cur_req = "R7";
    go(20, 0, 1, 2);
    rec(255, 0, 1, 2, 1, 1, 0);
    idx(); idx();

    // R8 side mismatch; last record decides (cylinder mismatch earlier)
    cur_req = "R8";
    go(5, 0, 3, 1);
    rec(6, 0, 3, 1, 1, 1, 0);
    rec(5, 1, 3, 1, 1, 1, 0);
    idx(); idx();
    go(5, 0, 3, 1);
    rec(5, 0, 3, 3, 1, 1, 0);
    idx(); idx();

    // R9 no records at all; R5 record without address mark skipped
    cur_req = "R9";
    go(1, 0, 1, 2);
    idx(); idle(4); idx();
    cur_req = "R5";
    go(1, 0, 1, 2);
    rec(1, 0, 1, 2, 0, 1, 0);
    rec(9, 1, 9, 9, 0, 0, 0);
    idx(); idx();

    // R10 CRC error terminates at once, index count irrelevant
    cur_req = "R10";
    go(2, 1, 4, 2);
    rec(7, 0, 0, 0, 1, 1, 0);
    rec(2, 1, 4, 2, 1, 0, 0);
    idle(2);

    // R1: restart mid-search and an index on the start cycle is not counted
    cur_req = "R1";
    go(4, 0, 2, 2);
    idx();
    tgt_track = 4; tgt_head = 0; tgt_sector = 2; tgt_size = 2;
    start = 1; index_pulse = 1; step();
    idx();
    idle(1);
    rec(4, 0, 2, 2, 1, 1, 0);

    // R11 record and second index in the same cycle
    cur_req = "R11";
    go(8, 0, 8, 2);
    idx();
    rec(8, 0, 8, 2, 1, 1, 1);      // hit wins
    go(8, 0, 8, 2);
    idx();
    rec(8, 0, 8, 2, 1, 0, 1);      // CRC error wins
    go(8, 0, 8, 2);
    rec(9, 0, 8, 2, 1, 1, 0);
    idx();
    rec(8, 1, 8, 2, 1, 1, 1);      // new mismatch used for status
    idle(2);

    // R6 second index ends search; first does not
    cur_req = "R6";
    go(0, 0, 0, 0);
    idx(); idle(3);
    chk("still busy after first index", busy, 1);
    idx();
    idle(1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule